// File: doc/BRIEF.md
# Prescaled Reloading Interval Timer

This block raises a periodic interrupt for a processor core. A 16-bit down-counter steps once per prescaler expiry. The prescaler is an internal 8-bit down-counter that reloads from a scale register. When a count step finds the counter already at zero, the counter reloads from a 16-bit period register and a one-cycle interrupt pulse is issued. The time between interrupts is therefore (period + 1) x (scale + 1) enabled clock cycles.

Software loads the counter, the period and the scale through a single write port with a 2-bit register select. All three registers can be read back at all times on dedicated output ports. An enable input freezes the counter and the prescaler without losing their state. Masking and routing of the interrupt are handled outside this block.

Top module: `interval_timer`

## Requirements
- R1: While reset is asserted and just after it is released, the count, period and scale read-back ports are all zero and the interrupt is low.
- R2: A write on a clock edge with wr_en high stores wr_data according to wr_sel. 0 selects the count, 1 the period, and 2 the scale (from the low 8 bits). The stored value appears on the matching read-back port after that edge, whatever the enable. Select value 3 changes no register.
- R3: While enable is high, the count changes only once every (scale + 1) cycles. With scale 0 it steps on every cycle.
- R4: When a count step happens while the count is zero, the count reloads from the period register. Otherwise the count decrements by one.
- R5: The interrupt is high for exactly the cycle in which a reloaded count first appears, and is low in all other cycles.
- R6: While enable is low, the count and the prescaler hold their values and no interrupt is raised.
- R7: A write to the count restarts the prescaler from the scale value, so the first step follows (scale + 1) enabled cycles later. No interrupt is issued for the cycle of that write.
- R8: A write to the scale does not disturb a prescaler run already in progress. The new value applies from the next prescaler reload.
- R9: With a period of 0, every count step after the count reaches zero raises an interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows the prescaler and the counter to advance |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 count, 1 period, 2 scale, 3 none |
| wr_data | input | 16 | Write data |
| count_q | output | 16 | Current count |
| period_q | output | 16 | Period register |
| scale_q | output | 8 | Scale register |
| irq | output | 1 | One-cycle interrupt pulse on reload |

## Verification
Every combination of scale 0 to 3, period 0 to 4 and starting count 0 or 2 is run for many cycles. On each cycle the count and the interrupt are compared against a closed-form function of the number of enabled cycles since the count write. This separates an off-by-one in the prescaler from one in the reload, and it exposes period-0 behaviour and immediate reload from a zero start. Half of these runs drop enable for a window. That checks that time stops rather than the phase being lost. A scale write in the middle of a prescaler run shows whether the run in progress is wrongly restarted. A write with the unused select value shows that no register is touched.

// File: rtl/timer_pkg.sv
// Shared definitions for the interval timer.
// Assumes the prescale width does not exceed the count width.
package timer_pkg;
    localparam int CNT_W = 16;
    localparam int PRE_W = 8;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_SCALE  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/timer_regs.sv
// Holds the period and scale configuration registers.
// Assumes writes are single-cycle strobes. Scale is taken from the low bits.
module timer_regs #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] period,
    output logic [PRE_W-1:0] scale
);
    import timer_pkg::*;

    // Capture period and scale writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            scale  <= '0;
        end else if (wr_en) begin
            if (reg_sel_e'(wr_sel) == SEL_PERIOD) period <= wr_data;
            if (reg_sel_e'(wr_sel) == SEL_SCALE)  scale  <= wr_data[PRE_W-1:0];
        end
    end
endmodule

// File: rtl/timer_prescale.sv
// Prescaler down-counter. It issues a step strobe every (scale+1) enabled cycles.
// Assumes restart has priority and reloads the phase from the scale value.
module timer_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic [PRE_W-1:0] scale,
    output logic             step
);
    logic [PRE_W-1:0] phase;

    // Step fires on an enabled cycle whose phase has run out.
    always_comb step = enable && !restart && (phase == '0);

    // Advance the phase, reloading on expiry or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (restart)
            phase <= scale;
        else if (enable)
            phase <= (phase == '0) ? scale : phase - 1'b1;
    end
endmodule

// File: rtl/timer_counter.sv
// Main down-counter with reload from the period and a one-cycle interrupt.
// Assumes that a software load overrides a step in the same cycle.
module timer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    logic at_zero;

    // Detect the run-out condition.
    always_comb at_zero = (count == '0);

    // Update the count and pulse the interrupt on reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (load) begin
                count <= load_val;
            end else if (step) begin
                if (at_zero) begin
                    count <= period;
                    irq   <= 1'b1;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/interval_timer.sv
// Top of the prescaled reloading interval timer.
// Assumes a synchronous active-low reset and that writes are accepted whatever the enable.
module interval_timer #(
    parameter int CNT_W = timer_pkg::CNT_W,
    parameter int PRE_W = timer_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] period_q,
    output logic [PRE_W-1:0] scale_q,
    output logic             irq
);
    import timer_pkg::*;

    logic load_cnt;
    logic step;

    // Decode a software write to the count.
    always_comb load_cnt = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);

    timer_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .period(period_q), .scale(scale_q)
    );

    timer_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .enable(enable), .restart(load_cnt),
        .scale(scale_q), .step(step)
    );

    timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step), .load(load_cnt),
        .load_val(wr_data), .period(period_q), .count(count_q), .irq(irq)
    );
endmodule

// File: rtl/timer_checker.sv
// Port-level properties of the interval timer, bound onto the top module.
module timer_checker #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] period_q,
    input logic [PRE_W-1:0] scale_q,
    input logic             irq
);
    assert_hold_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(enable) && !$past(wr_en)) |-> $stable(count_q));

    assert_no_irq_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> !irq);

    assert_irq_from_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(count_q) == '0));

    assert_irq_with_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count_q == $past(period_q)));

    assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $past(count_q) != '0) |->
        (count_q == $past(count_q) || count_q == $past(count_q) - 1'b1));

    assert_count_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (count_q == $past(wr_data) && !irq));

    assert_scale_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> (scale_q == $past(wr_data[PRE_W-1:0])));
endmodule

bind interval_timer timer_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .count_q(count_q), .period_q(period_q),
    .scale_q(scale_q), .irq(irq)
);

// File: tb/test_interval_timer.sv
module test_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_q;
    logic [15:0] period_q;
    logic [7:0]  scale_q;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    interval_timer i_interval_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .count_q(count_q), .period_q(period_q),
        .scale_q(scale_q), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Expected count after k enabled cycles since a count write of c.
    function automatic int exp_cnt(int k, int s, int p, int c);
        int t = k / (s + 1);
        if (t <= c) return c - t;
        return p - ((t - c - 1) % (p + 1));
    endfunction

    function automatic bit exp_irq(int k, int s, int p, int c);
        int t = k / (s + 1);
        return (k > 0) && (k % (s + 1) == 0) && (t > c) && ((t - c - 1) % (p + 1) == 0);
    endfunction

    // Configure, load the count, then run n cycles with enable dropped in [da, db).
    task automatic sweep_one(input int s, input int p, input int c,
                             input int n, input int da, input int db);
        int k = 0;
        enable = 1'b0;
        wr(2'd2, 16'(s));
        chk(scale_q == 8'(s), "R2 scale readback", scale_q, s);
        wr(2'd1, 16'(p));
        chk(period_q == 16'(p), "R2 period readback", period_q, p);
        wr(2'd0, 16'(c));
        chk(count_q == 16'(c) && !irq, "R7 count load", count_q, c);
        for (int i = 0; i < n; i++) begin
            enable = !(i >= da && i < db);
            @(posedge clk);
            @(negedge clk);
            if (enable) k++;
            chk(count_q == 16'(exp_cnt(k, s, p, c)), "R3/R4 count",
                count_q, exp_cnt(k, s, p, c));
            if (!enable)
                chk(!irq, "R6 irq held off", irq, 0);
            else if (p == 0)
                chk(irq == exp_irq(k, s, p, c), "R9 irq period zero", irq, exp_irq(k, s, p, c));
            else
                chk(irq == exp_irq(k, s, p, c), "R5 irq pulse", irq, exp_irq(k, s, p, c));
        end
        enable = 1'b0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(count_q == 0 && period_q == 0 && scale_q == 0 && !irq, "R1 reset",
            int'(count_q) + int'(period_q) + int'(scale_q) + int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(count_q == 0 && period_q == 0 && scale_q == 0 && !irq, "R1 after release",
            int'(count_q) + int'(period_q) + int'(scale_q) + int'(irq), 0);

        // R3, R4, R5, R6, R9: sweep all small configurations
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 5; p++)
                for (int c = 0; c < 3; c += 2)
                    if (c == 2) sweep_one(s, p, c, 40, 5, 10);
                    else        sweep_one(s, p, c, 40, 0, 0);

        // R2: unused select value changes nothing
        wr(2'd2, 16'd3);
        wr(2'd1, 16'd7);
        wr(2'd0, 16'd11);
        wr(2'd3, 16'hFFFF);
        chk(count_q == 16'd11, "R2 sel3 count", count_q, 11);
        chk(period_q == 16'd7, "R2 sel3 period", period_q, 7);
        chk(scale_q == 8'd3, "R2 sel3 scale", scale_q, 3);

        // R8: scale write mid-run keeps the current prescaler phase
        wr(2'd0, 16'd10);
        for (int i = 0; i < 2; i++) begin
            enable = 1'b1;
            @(posedge clk);
            @(negedge clk);
        end
        enable = 1'b0;
        chk(count_q == 16'd10, "R8 before scale write", count_q, 10);
        wr(2'd2, 16'd0);
        enable = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(count_q == 16'd10, "R8 phase kept", count_q, 10);
        @(posedge clk); @(negedge clk);
        chk(count_q == 16'd9, "R8 old phase expires", count_q, 9);
        @(posedge clk); @(negedge clk);
        chk(count_q == 16'd8, "R8 new scale applies", count_q, 8);

        // R7: count write while running restarts the prescaler
        wr(2'd2, 16'd2);
        wr(2'd0, 16'd5);
        chk(count_q == 16'd5, "R7 reload value", count_q, 5);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk(count_q == 16'd5, "R7 prescaler restarted", count_q, 5);
        @(posedge clk); @(negedge clk);
        chk(count_q == 16'd4, "R7 first step", count_q, 4);
        enable = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule